// File: doc/BRIEF.md
# Serial Register-Access Command Port

This block is the serial slave port of a measurement converter's register bank. A host drives a serial clock, an active-low select, and a data-in line. The block answers on a data-out line. Every access opens with an 8-bit command. The command names one of eight register slots, gives the direction of the access, and also carries a standby request and a two-bit channel choice. The block then moves exactly one payload of the width that belongs to the named slot. Writes are committed into local storage. Reads are shifted out most significant bit first. After the payload, the port goes back to waiting for the next command.

The serial lines are sampled by the block's own system clock, and all logic runs in that one clock domain. The conversion result and its ready flag come from outside the block. A long run of ones on the data-in line brings a host that has lost count back to the command phase. Raising the select line abandons any partial access.

Top module: `spi_reg_if`

## Requirements
- R1: After reset, the setup, clock-control, offset and gain registers read zero, `standby` and `chan` are 0, and `sdo_oe` is 0 while `cs_n` is high.
- R2: The first command bit must be 0. While `din` is 1 at that position, the port stays there and loads nothing. After a 0, the next seven bits are taken MSB first as: select in bits 6:4, read flag in bit 3 (1 = read), standby in bit 2, channel in bits 1:0.
- R3: A write commits on the last payload bit. Select 001 (setup) and 010 (clock control) take CFG_W bits. Select 110 (offset) and 111 (gain) take CAL_W bits. Each register drives its own output.
- R4: A read shifts the selected value out MSB first on `sdo`. `sdo` changes after a falling `sclk` edge and is valid at the next rising edge. Select 011 returns `conv_data` over DATA_W bits. A read of any writable register returns the value last written.
- R5: A read with select 000 returns 8 bits. Bit 7 is the inverse of `result_ready`, and bits 6:0 are the seven bits of the command just loaded.
- R6: Each command is followed by exactly one access, and then the next bits are taken as a new command. A write command with select 000 has no payload.
- R7: Selects 100 and 101 take 8-bit payloads. Writes to them change nothing, and reads of them return zero.
- R8: A write to select 011 consumes DATA_W bits, changes no register, and raises no `data_taken`.
- R9: RESYNC_ONES consecutive rising `sclk` edges with `din` high (default 32) return the port to the command phase at once, with no commit. A run one shorter has no effect.
- R10: `cs_n` high abandons any partial access without a commit or `data_taken`, and holds `sdo_oe` low. The next low period starts at the command phase.
- R11: `data_taken` pulses once for one clock cycle when a full read of select 011 completes.
- R12: `standby` and `chan` follow the last command loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle high |
| cs_n | input | 1 | Active-low frame select; may stay low |
| din | input | 1 | Serial data in, sampled at rising `sclk` |
| result_ready | input | 1 | High when a fresh conversion word waits |
| conv_data | input | DATA_W | Conversion result returned by select 011 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo`; the pad is released when low |
| setup_q | output | CFG_W | Setup register |
| clkcfg_q | output | CFG_W | Clock-control register |
| ofs_cal | output | CAL_W | Offset calibration register |
| gain_cal | output | CAL_W | Gain calibration register |
| standby | output | 1 | Standby request from the last command |
| chan | output | 2 | Channel choice from the last command |
| data_taken | output | 1 | One-cycle pulse after a full conversion read |

## Verification
The hardest situation to reach is the long-run recovery firing in the middle of an access. At the default widths it cannot happen. A command starts with a zero, so at most seven ones come from the command, and the longest payload is 24 bits. A run of ones therefore always ends the access before it reaches 32.

To make the case reachable, the bench shortens the threshold to 16. It then sends a gain write whose command ends in two ones, followed by fourteen ones, and checks that nothing is committed and that the next bits are decoded as a fresh command. It also covers the boundary from the other side: a run of fifteen ones followed by a zero completes a normal write.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_XFER = 2'd2
  } phase_e;

  typedef struct packed {
    logic [2:0] sel;
    logic       rd;
    logic       stby;
    logic [1:0] ch;
  } cmd_t;

  localparam logic [2:0] SEL_COMM  = 3'd0;
  localparam logic [2:0] SEL_SETUP = 3'd1;
  localparam logic [2:0] SEL_CLK   = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_OFS   = 3'd6;
  localparam logic [2:0] SEL_GAIN  = 3'd7;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic din_s
);
  logic [SYNC_STAGES-1:0] sclk_p, cs_p, din_p;
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '1;
      cs_p   <= '1;
      din_p  <= '1;
      sclk_d <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      din_p  <= {din_p[SYNC_STAGES-2:0], din};
      sclk_d <= sclk_p[SYNC_STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[SYNC_STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[SYNC_STAGES-1] & sclk_d;
  assign cs_act    = ~cs_p[SYNC_STAGES-1];
  assign din_s     = din_p[SYNC_STAGES-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int DATA_W = 16,
  parameter int CAL_W  = 24,
  parameter int SH_W   = 24,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic              wr_stb,
  input  logic [SH_W-1:0]   wr_word,
  input  logic              result_ready,
  input  logic [DATA_W-1:0] conv_data,
  output logic [SH_W-1:0]   rd_word,
  output logic [LEN_W-1:0]  acc_len,
  output logic [CFG_W-1:0]  setup_q,
  output logic [CFG_W-1:0]  clkcfg_q,
  output logic [CAL_W-1:0]  ofs_q,
  output logic [CAL_W-1:0]  gain_q
);
  logic [CFG_W-1:0] setup_n, clkcfg_n;
  logic [CAL_W-1:0] ofs_n, gain_n;

  always_comb begin
    setup_n  = setup_q;
    clkcfg_n = clkcfg_q;
    ofs_n    = ofs_q;
    gain_n   = gain_q;
    if (wr_stb) begin
      case (cmd.sel)
        SEL_SETUP: setup_n  = wr_word[CFG_W-1:0];
        SEL_CLK:   clkcfg_n = wr_word[CFG_W-1:0];
        SEL_OFS:   ofs_n    = wr_word[CAL_W-1:0];
        SEL_GAIN:  gain_n   = wr_word[CAL_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q  <= '0;
      clkcfg_q <= '0;
      ofs_q    <= '0;
      gain_q   <= '0;
    end else begin
      setup_q  <= setup_n;
      clkcfg_q <= clkcfg_n;
      ofs_q    <= ofs_n;
      gain_q   <= gain_n;
    end
  end

  always_comb begin
    rd_word = '0;
    acc_len = LEN_W'(8);
    case (cmd.sel)
      SEL_COMM:  rd_word[SH_W-1 -: 8] = {~result_ready, cmd};
      SEL_SETUP: begin rd_word[SH_W-1 -: CFG_W] = setup_q;  acc_len = LEN_W'(CFG_W);  end
      SEL_CLK:   begin rd_word[SH_W-1 -: CFG_W] = clkcfg_q; acc_len = LEN_W'(CFG_W);  end
      SEL_DATA:  begin rd_word[SH_W-1 -: DATA_W] = conv_data; acc_len = LEN_W'(DATA_W); end
      SEL_OFS:   begin rd_word[SH_W-1 -: CAL_W] = ofs_q;    acc_len = LEN_W'(CAL_W);  end
      SEL_GAIN:  begin rd_word[SH_W-1 -: CAL_W] = gain_q;   acc_len = LEN_W'(CAL_W);  end
      default:   ;
    endcase
  end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SH_W        = 24,
  parameter int LEN_W       = 5,
  parameter int RESYNC_ONES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             cs_act,
  input  logic             din_s,
  input  logic [SH_W-1:0]  rd_word,
  input  logic [LEN_W-1:0] acc_len,
  output cmd_t             cmd_q,
  output logic             cmd_load,
  output logic             wr_stb,
  output logic             rd_done,
  output logic [SH_W-1:0]  wr_word,
  output logic             dout_q,
  output phase_e           phase_q
);
  localparam int ONES_W = $clog2(RESYNC_ONES + 1);

  phase_e            phase_n;
  cmd_t              cmd_n;
  logic [LEN_W-1:0]  bit_q, bit_n;
  logic [ONES_W-1:0] ones_q, ones_n;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic              load_q, load_n, dout_n, resync;

  always_comb begin
    phase_n  = phase_q;
    cmd_n    = cmd_q;
    bit_n    = bit_q;
    ones_n   = ones_q;
    sh_n     = sh_q;
    load_n   = 1'b0;
    dout_n   = dout_q;
    cmd_load = 1'b0;
    wr_stb   = 1'b0;
    rd_done  = 1'b0;
    wr_word  = {sh_q[SH_W-2:0], din_s};
    resync   = sclk_rise && din_s && (ones_q == ONES_W'(RESYNC_ONES - 1));
    if (!cs_act) begin
      phase_n = ST_IDLE;
      bit_n   = '0;
      ones_n  = '0;
    end else begin
      if (load_q) sh_n = rd_word;
      if (sclk_rise) ones_n = din_s ? ones_q + 1'b1 : '0;
      if (resync) begin
        phase_n = ST_IDLE;
        bit_n   = '0;
        ones_n  = '0;
      end else if (sclk_rise) begin
        case (phase_q)
          ST_IDLE: begin
            if (!din_s) begin
              phase_n = ST_CMD;
              bit_n   = '0;
            end
          end
          ST_CMD: begin
            sh_n  = {sh_q[SH_W-2:0], din_s};
            bit_n = bit_q + 1'b1;
            if (bit_q == LEN_W'(6)) begin
              cmd_n    = cmd_t'({sh_q[5:0], din_s});
              cmd_load = 1'b1;
              bit_n    = '0;
              if (cmd_n.sel == SEL_COMM && !cmd_n.rd) begin
                phase_n = ST_IDLE;
              end else begin
                phase_n = ST_XFER;
                load_n  = 1'b1;
              end
            end
          end
          ST_XFER: begin
            bit_n = bit_q + 1'b1;
            sh_n  = cmd_q.rd ? {sh_q[SH_W-2:0], 1'b0} : wr_word;
            if (bit_q == acc_len - 1'b1) begin
              phase_n = ST_IDLE;
              bit_n   = '0;
              wr_stb  = !cmd_q.rd;
              rd_done = cmd_q.rd;
            end
          end
          default: phase_n = ST_IDLE;
        endcase
      end
      if (sclk_fall && phase_q == ST_XFER && cmd_q.rd) dout_n = sh_q[SH_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      cmd_q   <= '0;
      bit_q   <= '0;
      ones_q  <= '0;
      sh_q    <= '0;
      load_q  <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cmd_q   <= cmd_n;
      bit_q   <= bit_n;
      ones_q  <= ones_n;
      sh_q    <= sh_n;
      load_q  <= load_n;
      dout_q  <= dout_n;
    end
  end
endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_reg_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int DATA_W      = 16,
  parameter int CAL_W       = 24,
  parameter int RESYNC_ONES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              result_ready,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [CFG_W-1:0]  setup_q,
  output logic [CFG_W-1:0]  clkcfg_q,
  output logic [CAL_W-1:0]  ofs_cal,
  output logic [CAL_W-1:0]  gain_cal,
  output logic              standby,
  output logic [1:0]        chan,
  output logic              data_taken
);
  localparam int W_A   = (CAL_W > DATA_W) ? CAL_W : DATA_W;
  localparam int W_B   = (W_A > CFG_W) ? W_A : CFG_W;
  localparam int SH_W  = (W_B > 8) ? W_B : 8;
  localparam int LEN_W = $clog2(SH_W + 1);

  logic             sclk_rise, sclk_fall, cs_act, din_s;
  logic             cmd_load, wr_stb, rd_done, dout_q;
  logic [SH_W-1:0]  rd_word, wr_word;
  logic [LEN_W-1:0] acc_len;
  cmd_t             cmd_q;
  phase_e           phase_q;

  spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .din_s(din_s)
  );

  spi_frame_ctrl #(.SH_W(SH_W), .LEN_W(LEN_W), .RESYNC_ONES(RESYNC_ONES)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .din_s(din_s), .rd_word(rd_word), .acc_len(acc_len),
    .cmd_q(cmd_q), .cmd_load(cmd_load), .wr_stb(wr_stb), .rd_done(rd_done),
    .wr_word(wr_word), .dout_q(dout_q), .phase_q(phase_q)
  );

  spi_reg_bank #(.CFG_W(CFG_W), .DATA_W(DATA_W), .CAL_W(CAL_W), .SH_W(SH_W), .LEN_W(LEN_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .wr_stb(wr_stb), .wr_word(wr_word),
    .result_ready(result_ready), .conv_data(conv_data), .rd_word(rd_word),
    .acc_len(acc_len), .setup_q(setup_q), .clkcfg_q(clkcfg_q),
    .ofs_q(ofs_cal), .gain_q(gain_cal)
  );

  assign sdo        = dout_q;
  assign sdo_oe     = cs_act;
  assign standby    = cmd_q.stby;
  assign chan       = cmd_q.ch;
  assign data_taken = rd_done && (cmd_q.sel == SEL_DATA);
endmodule

// File: rtl/spi_reg_if_chk.sv
module spi_reg_if_chk
  import spi_reg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_act,
  input phase_e phase_q,
  input cmd_t   cmd_q,
  input logic   cmd_load,
  input logic   wr_stb,
  input logic   rd_done,
  input logic   data_taken
);
  a_r10_idle_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> phase_q == ST_IDLE);

  a_r10_fresh_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |-> phase_q == ST_IDLE);

  a_r3_commit_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (phase_q == ST_XFER && !cmd_q.rd));

  a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_done) |=> phase_q == ST_IDLE);

  a_r12_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_load |=> $stable(cmd_q));

  a_r11_taken_ends: assert property (@(posedge clk) disable iff (!rst_n)
    data_taken |=> (phase_q == ST_IDLE && !data_taken));

  a_r6_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_done, cmd_load}));
endmodule

bind spi_reg_if spi_reg_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .phase_q(phase_q), .cmd_q(cmd_q),
  .cmd_load(cmd_load), .wr_stb(wr_stb), .rd_done(rd_done), .data_taken(data_taken)
);

// File: tb/spi_reg_if_tb.sv
module spi_reg_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int RESYNC     = 16;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, din, result_ready;
  logic [15:0] conv_data;
  logic sdo, sdo_oe, standby, data_taken;
  logic [7:0] setup_q, clkcfg_q;
  logic [23:0] ofs_cal, gain_cal;
  logic [1:0] chan;

  int checks = 0;
  int errors = 0;
  int taken  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (data_taken) taken++;

  spi_reg_if #(.RESYNC_ONES(RESYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .result_ready(result_ready), .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .setup_q(setup_q), .clkcfg_q(clkcfg_q), .ofs_cal(ofs_cal), .gain_cal(gain_cal),
    .standby(standby), .chan(chan), .data_taken(data_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      din  = tx[i];
      wait_clks(HALF);
      rx[i] = sdo;
      sclk = 1'b1;
      wait_clks(HALF);
    end
  endtask

  task automatic send(input logic [31:0] tx, input int n);
    logic [31:0] d;
    xfer(tx, n, d);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rx;
    logic [15:0] pat;
    logic [23:0] gexp;
    int t0;
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; din = 1'b1;
    result_ready = 1'b0; conv_data = '0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);

    // R1 reset state
    chk("R1 setup", 32'(setup_q), 0);
    chk("R1 clkcfg", 32'(clkcfg_q), 0);
    chk("R1 ofs", 32'(ofs_cal), 0);
    chk("R1 gain", 32'(gain_cal), 0);
    chk("R1 standby", 32'(standby), 0);
    chk("R1 chan", 32'(chan), 0);
    chk("R1 oe", 32'(sdo_oe), 0);

    cs_n = 1'b0;
    wait_clks(4);
    chk("R10 oe low cs", 32'(sdo_oe), 1);

    // R2 leading ones are idle, then a command loads
    send(32'h1F, 5);
    send(32'h10, 8);
    send(32'hA5, 8);
    wait_clks(2);
    chk("R2 setup after leading ones", 32'(setup_q), 32'hA5);

    // R3 / R12 sweep of the setup register, R4 periodic readback
    for (int v = 0; v < 256; v++) begin
      send(32'h10 | (v & 3), 8);
      send(32'(v), 8);
      wait_clks(2);
      chk("R3 setup sweep", 32'(setup_q), 32'(v));
      chk("R12 chan", 32'(chan), 32'(v & 3));
      if (v % 32 == 7) begin
        send(32'h18, 8);
        xfer(0, 8, rx);
        chk("R4 setup readback", rx, 32'(v));
      end
    end

    // R3 clock control and calibration registers
    send(32'h20, 8); send(32'h3C, 8); wait_clks(2);
    chk("R3 clkcfg", 32'(clkcfg_q), 32'h3C);
    send(32'h28, 8); xfer(0, 8, rx);
    chk("R4 clkcfg readback", rx, 32'h3C);
    send(32'h60, 8); send(32'h123456, 24);
    send(32'h70, 8); send(32'hABCDEF, 24); wait_clks(2);
    chk("R3 ofs", 32'(ofs_cal), 32'h123456);
    chk("R3 gain", 32'(gain_cal), 32'hABCDEF);
    send(32'h68, 8); xfer(0, 24, rx);
    chk("R4 ofs readback", rx, 32'h123456);
    send(32'h78, 8); xfer(0, 24, rx);
    chk("R4 gain readback", rx, 32'hABCDEF);

    // R4 / R11 conversion data reads
    for (int k = 0; k < 6; k++) begin
      pat = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'(16'h8001 ^ (k * 16'h1357));
      conv_data = pat;
      t0 = taken;
      send(32'h38, 8);
      xfer(0, 16, rx);
      wait_clks(2);
      chk("R4 data read", rx, 32'(pat));
      chk("R11 taken pulse", 32'(taken), 32'(t0 + 1));
    end

    // R8 data register write is ignored but framed
    t0 = taken;
    send(32'h30, 8); send(32'h5AC3, 16);
    send(32'h10, 8); send(32'h66, 8); wait_clks(2);
    chk("R8 framing", 32'(setup_q), 32'h66);
    chk("R8 no taken", 32'(taken), 32'(t0));
    chk("R8 clkcfg kept", 32'(clkcfg_q), 32'h3C);

    // R5 communications read with ready status
    result_ready = 1'b1;
    send(32'h0C, 8); xfer(0, 8, rx);
    chk("R5 comm read ready", rx, 32'h0C);
    chk("R12 standby set", 32'(standby), 1);
    result_ready = 1'b0;
    send(32'h09, 8); xfer(0, 8, rx);
    chk("R5 comm read not ready", rx, 32'h89);
    chk("R12 standby clear", 32'(standby), 0);
    chk("R12 chan one", 32'(chan), 1);

    // R6 command write without payload, then back to back accesses
    send(32'h00, 8);
    send(32'h10, 8); send(32'h5A, 8); wait_clks(2);
    chk("R6 after comm write", 32'(setup_q), 32'h5A);
    send(32'h28, 8); xfer(0, 8, rx);
    chk("R6 next command", rx, 32'h3C);

    // R7 reserved selects
    send(32'h40, 8); send(32'hC3, 8);
    send(32'h48, 8); xfer(0, 8, rx);
    chk("R7 read zero 100", rx, 0);
    send(32'h58, 8); xfer(0, 8, rx);
    chk("R7 read zero 101", rx, 0);
    chk("R7 setup kept", 32'(setup_q), 32'h5A);
    chk("R7 clkcfg kept", 32'(clkcfg_q), 32'h3C);

    // R9 boundary: run of RESYNC-1 ones then a zero completes normally
    gexp = 24'(((1 << 13) - 1) << 11) | 24'h2AA;
    send(32'h73, 8); send(32'(gexp), 24); wait_clks(2);
    chk("R9 run below threshold", 32'(gain_cal), 32'(gexp));
    // R9 run reaching the threshold inside a gain write
    send(32'h73, 8); send(32'h3FFF, 14);
    send(32'h10, 8); send(32'h21, 8); wait_clks(2);
    chk("R9 resync no commit", 32'(gain_cal), 32'(gexp));
    chk("R9 resync next command", 32'(setup_q), 32'h21);

    // R10 select release aborts a write and a read
    send(32'h20, 8); send(32'h5, 4);
    cs_n = 1'b1; wait_clks(6);
    chk("R10 oe released", 32'(sdo_oe), 0);
    chk("R10 no commit", 32'(clkcfg_q), 32'h3C);
    cs_n = 1'b0; wait_clks(4);
    t0 = taken;
    send(32'h38, 8); xfer(0, 5, rx);
    cs_n = 1'b1; wait_clks(6);
    chk("R10 read abort no taken", 32'(taken), 32'(t0));
    cs_n = 1'b0; wait_clks(4);
    send(32'h20, 8); send(32'h81, 8); wait_clks(2);
    chk("R10 fresh frame", 32'(clkcfg_q), 32'h81);

    summary();
    $finish;
  end
endmodule